// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 16-bit buses, side A and side B, through two byte lanes. Each lane either copies one bus onto the other as it arrives, or drives the other bus from a storage register. There is one storage register per direction. It captures on the rising edge of a strobe, and it captures whatever the lane's enable and direction settings are. Each lane has its own set of controls: an active-low output enable, a direction select, two capture strobes and two source selects.

The bidirectional pins are split into an input vector, an output vector and a per-bit output-enable vector for each bus. A pad ring or tri-state wrapper at the chip level merges them. The capture strobes are sampled on the single system clock. A low-to-high change seen between two clock edges acts as a capture request.

Top module: `bus_xcvr16`

## Requirements
- R1: While lane n's `lane_off_ni[n]`... is high, the lane is isolated. Both `a_oe_o` and `b_oe_o` are zero over bits 8n+7..8n. Lane 0 is bits 7:0 and lane 1 is bits 15:8.
- R2: When isolation is off and `dir_i[n]` is 1, all eight bits of lane n in `b_oe_o` are 1 and in `a_oe_o` are 0. When `dir_i[n]` is 0, the reverse holds. The two enables of a bit are never both 1.
- R3: With `sel_ab_i[n]` = 0, `b_o` for lane n equals the lane's `a_i` in the same cycle (combinational, non-inverting).
- R4: With `sel_ab_i[n]` = 1, `b_o` for lane n equals the A-to-B storage register of that lane.
- R5: With `sel_ba_i[n]` = 0, `a_o` for lane n equals the lane's `b_i` in the same cycle. With `sel_ba_i[n]` = 1, `a_o` equals the B-to-A storage register.
- R6: The A-to-B register of lane n loads the lane's `a_i` on the clock edge where `cap_ab_i[n]` is 1 and was 0 at the previous edge. It loads at no other time.
- R7: The B-to-A register of lane n loads the lane's `b_i` on the clock edge where `cap_ba_i[n]` is 1 and was 0 at the previous edge. It loads at no other time.
- R8: Capture takes place whatever the lane's isolation and direction settings are.
- R9: In stored mode, a captured value shows on the opposite output right after the capturing edge.
- R10: While `rst_ni` is low, both registers clear to zero, both enable vectors are zero, and the strobe history is cleared. A strobe held high through reset therefore captures on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lane_off_ni | input | 2 | Per-lane isolation, high = drive neither bus |
| dir_i | input | 2 | Per-lane direction, 1 = A to B |
| cap_ab_i | input | 2 | Per-lane A-side capture strobe |
| cap_ba_i | input | 2 | Per-lane B-side capture strobe |
| sel_ab_i | input | 2 | Per-lane B output source, 1 = stored |
| sel_ba_i | input | 2 | Per-lane A output source, 1 = stored |
| a_i | input | 16 | A bus sampled value |
| a_o | output | 16 | A bus drive value |
| a_oe_o | output | 16 | A bus per-bit drive enable |
| b_i | input | 16 | B bus sampled value |
| b_o | output | 16 | B bus drive value |
| b_oe_o | output | 16 | B bus per-bit drive enable |

## Verification
A register that has captured the wrong word, or captured on the wrong edge, stays invisible until its lane is put in stored mode. From then on it shows on the opposite output in the same cycle. For this reason the bench toggles stored mode on every few vectors, whatever the enable state. A strobe edge detector that is stuck or double-fires shows one clock later as a stale or changed stored value. A wrong decode of the enables shows at once on the enable vectors, in every combination of isolation and direction.

// File: rtl/bus_xcvr16_pkg.sv
package bus_xcvr16_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned BUS_W  = LANE_W * LANES;

  typedef logic [LANE_W-1:0] lane_t;

  typedef struct packed {
    logic off_n;
    logic dir;
    logic sel_ab;
    logic sel_ba;
  } lane_ctl_t;
endpackage

// File: rtl/xcvr_edge_det.sv
module xcvr_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= strobe_i;
  end

  assign rise_o = strobe_i & ~prev_q;
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import bus_xcvr16_pkg::*;
#(
  parameter int unsigned W = LANE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  lane_ctl_t    ctl_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  logic         ab_rise, ba_rise;
  logic [W-1:0] ab_q, ba_q;
  logic         drive_b, drive_a;

  xcvr_edge_det u_ab_edge (.clk_i, .rst_ni, .strobe_i(cap_ab_i), .rise_o(ab_rise));
  xcvr_edge_det u_ba_edge (.clk_i, .rst_ni, .strobe_i(cap_ba_i), .rise_o(ba_rise));

  xcvr_store #(.W(W)) u_ab_reg (.clk_i, .rst_ni, .load_i(ab_rise), .d_i(a_i), .q_o(ab_q));
  xcvr_store #(.W(W)) u_ba_reg (.clk_i, .rst_ni, .load_i(ba_rise), .d_i(b_i), .q_o(ba_q));

  // enables held off in reset
  assign drive_b = rst_ni & ~ctl_i.off_n &  ctl_i.dir;
  assign drive_a = rst_ni & ~ctl_i.off_n & ~ctl_i.dir;

  assign b_o    = ctl_i.sel_ab ? ab_q : a_i;
  assign a_o    = ctl_i.sel_ba ? ba_q : b_i;
  assign b_oe_o = {W{drive_b}};
  assign a_oe_o = {W{drive_a}};
endmodule

// File: rtl/bus_xcvr16.sv
module bus_xcvr16
  import bus_xcvr16_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_off_ni,
  input  logic [LANES-1:0] dir_i,
  input  logic [LANES-1:0] cap_ab_i,
  input  logic [LANES-1:0] cap_ba_i,
  input  logic [LANES-1:0] sel_ab_i,
  input  logic [LANES-1:0] sel_ba_i,
  input  logic [BUS_W-1:0] a_i,
  output logic [BUS_W-1:0] a_o,
  output logic [BUS_W-1:0] a_oe_o,
  input  logic [BUS_W-1:0] b_i,
  output logic [BUS_W-1:0] b_o,
  output logic [BUS_W-1:0] b_oe_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_ctl_t ctl;
    assign ctl = '{off_n: lane_off_ni[g], dir: dir_i[g],
                   sel_ab: sel_ab_i[g], sel_ba: sel_ba_i[g]};

    xcvr_lane #(.W(LANE_W)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_i    (ctl),
      .cap_ab_i (cap_ab_i[g]),
      .cap_ba_i (cap_ba_i[g]),
      .a_i      (a_i[g*LANE_W +: LANE_W]),
      .b_i      (b_i[g*LANE_W +: LANE_W]),
      .a_o      (a_o[g*LANE_W +: LANE_W]),
      .a_oe_o   (a_oe_o[g*LANE_W +: LANE_W]),
      .b_o      (b_o[g*LANE_W +: LANE_W]),
      .b_oe_o   (b_oe_o[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/bus_xcvr16_chk.sv
module bus_xcvr16_chk
  import bus_xcvr16_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LANES-1:0] lane_off_ni,
  input logic [LANES-1:0] dir_i,
  input logic [LANES-1:0] cap_ab_i,
  input logic [LANES-1:0] cap_ba_i,
  input logic [LANES-1:0] sel_ab_i,
  input logic [LANES-1:0] sel_ba_i,
  input logic [BUS_W-1:0] a_i,
  input logic [BUS_W-1:0] a_o,
  input logic [BUS_W-1:0] a_oe_o,
  input logic [BUS_W-1:0] b_i,
  input logic [BUS_W-1:0] b_o,
  input logic [BUS_W-1:0] b_oe_o
);
  // R2
  oe_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o & b_oe_o) == '0);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    localparam int unsigned L = g * LANE_W;
    // R1
    iso_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_off_ni[g] |-> (a_oe_o[L +: LANE_W] == '0 && b_oe_o[L +: LANE_W] == '0));
    // R3
    ab_transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_ab_i[g] |-> b_o[L +: LANE_W] == a_i[L +: LANE_W]);
    // R5
    ba_transparent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_ba_i[g] |-> a_o[L +: LANE_W] == b_i[L +: LANE_W]);
    // R9
    ab_stored_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cap_ab_i[g] && !$past(cap_ab_i[g]) && $past(rst_ni)) ##1 sel_ab_i[g]
        |-> b_o[L +: LANE_W] == $past(a_i[L +: LANE_W]));
    // R6
    ab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sel_ab_i[g] && $past(sel_ab_i[g]) && $past(rst_ni)
        && !(cap_ab_i[g] && !$past(cap_ab_i[g]))) |=> sel_ab_i[g] |-> $stable(b_o[L +: LANE_W]));
  end
endmodule

bind bus_xcvr16 bus_xcvr16_chk u_chk (.*);

// File: tb/tb_bus_xcvr16.sv
`timescale 1ns/1ps
module tb_bus_xcvr16;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  lane_off_ni = 2'b11, dir_i = '0, cap_ab_i = '0, cap_ba_i = '0;
  logic [1:0]  sel_ab_i = '0, sel_ba_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [15:0] a_o, a_oe_o, b_o, b_oe_o;

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_ab [2];
  logic [7:0] m_ba [2];
  bit         m_pab [2];
  bit         m_pba [2];

  bus_xcvr16 dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] exp_b();
    logic [15:0] r;
    for (int l = 0; l < 2; l++) r[l*8 +: 8] = sel_ab_i[l] ? m_ab[l] : a_i[l*8 +: 8];
    return r;
  endfunction
  function automatic logic [15:0] exp_a();
    logic [15:0] r;
    for (int l = 0; l < 2; l++) r[l*8 +: 8] = sel_ba_i[l] ? m_ba[l] : b_i[l*8 +: 8];
    return r;
  endfunction
  function automatic logic [15:0] exp_oe(input bit side_b);
    logic [15:0] r;
    for (int l = 0; l < 2; l++)
      r[l*8 +: 8] = {8{rst_ni && !lane_off_ni[l] && (dir_i[l] == side_b)}};
    return r;
  endfunction

  task automatic compare_all();
    check("R3/R4 b_o", b_o, exp_b());
    check("R5 a_o", a_o, exp_a());
    check("R1/R2 b_oe", b_oe_o, exp_oe(1'b1));
    check("R1/R2 a_oe", a_oe_o, exp_oe(1'b0));
  endtask

  // model update at the edge (R6 R7 R8 R10)
  always @(posedge clk_i) begin
    for (int l = 0; l < 2; l++) begin
      if (!rst_ni) begin
        m_ab[l] <= '0; m_ba[l] <= '0; m_pab[l] <= 0; m_pba[l] <= 0;
      end else begin
        if (cap_ab_i[l] && !m_pab[l]) m_ab[l] <= a_i[l*8 +: 8];
        if (cap_ba_i[l] && !m_pba[l]) m_ba[l] <= b_i[l*8 +: 8];
        m_pab[l] <= cap_ab_i[l];
        m_pba[l] <= cap_ba_i[l];
      end
    end
  end

  // drive after the rising edge, compare before the next one
  task automatic step();
    @(posedge clk_i); #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state with strobe held high
    cap_ab_i = 2'b01; sel_ab_i = 2'b11; sel_ba_i = 2'b11; lane_off_ni = 2'b00;
    a_i = 16'h5aa5;
    repeat (3) step();
    #2 check("R10 a_oe reset", a_oe_o, 16'h0);
    check("R10 b_oe reset", b_oe_o, 16'h0);
    check("R10 b_o reset", b_o, 16'h0);
    @(negedge clk_i) rst_ni = 1'b1;
    step();
    // R10: held strobe captures on first edge after reset
    check("R10 first capture", b_o, {8'h00, 8'ha5});
    cap_ab_i = 2'b00; a_i = 16'h1111;
    step();
    // R6: no capture without rising edge
    check("R6 hold", b_o, {8'h00, 8'ha5});

    // R8/R9: capture during isolation, both lanes, both directions
    lane_off_ni = 2'b11; sel_ab_i = 2'b11; sel_ba_i = 2'b11;
    a_i = 16'hc3d4; b_i = 16'h9e17; cap_ab_i = 2'b11; cap_ba_i = 2'b11;
    step();
    check("R8 iso a_oe", a_oe_o, 16'h0);
    check("R9 stored b_o", b_o, 16'hc3d4);
    check("R7 stored a_o", a_o, 16'h9e17);
    cap_ab_i = 2'b00; cap_ba_i = 2'b00;
    step();

    // exhaustive per-lane control sweep against model
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc;
      cc = c[7:0];
      lane_off_ni = {cc[4], cc[0]};
      dir_i       = {cc[5], cc[1]};
      sel_ab_i    = {cc[6], cc[2]};
      sel_ba_i    = {cc[7], cc[3]};
      a_i = 16'(c * 16'h9d37 + 16'h0123);
      b_i = 16'(c * 16'h4b1f + 16'h7e00);
      cap_ab_i = 2'(c % 3);
      cap_ba_i = 2'((c >> 1) % 3);
      #2 compare_all();
      step();
      compare_all();
    end

    // R2/R1 explicit decode
    lane_off_ni = 2'b00; dir_i = 2'b01;
    #1 check("R2 b_oe dir", b_oe_o, 16'h00ff);
    check("R2 a_oe dir", a_oe_o, 16'hff00);
    lane_off_ni = 2'b10;
    #1 check("R1 iso lane1", a_oe_o, 16'h0000);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule